// File: doc/BRIEF.md
# Sticky-Pending Interrupt Aggregator

This block gathers a bank of level-sensitive interrupt request lines into one interrupt output for a processor. Each line is passed through a synchroniser and then sets a sticky pending bit. The pending bit stays set after the line drops, until software acknowledges it. A mask register chooses which pending lines may raise the output. Software reaches the mask, the pending bits and a set of per-line event counters through a plain register port. Writes take effect at the clock edge. Reads are combinational.

A write of ones to the pending register clears those bits. A line whose synchronised level is still high sets its bit again in that same cycle, so a held level cannot be acknowledged away. Each line also has a wide counter, read in two 32-bit halves, that records how many times the synchronised line has gone from low to high. The counter wraps to zero when it overflows.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: `irq_out` is 1 exactly when at least one line has both its pending bit and its mask bit set. The output is driven from registered state only.
- R2: A level on `irq_lines[i]` that is present before clock edge k sets pending bit i at edge k+2. This is a two-flop synchroniser followed by the pending register. A single-cycle pulse is enough to set the bit.
- R3: Once set, a pending bit stays set after its line returns low, until it is acknowledged.
- R4: A write to address 0x01 is an acknowledge. Each bit written as 1 clears that pending bit at the write edge. Each bit written as 0 leaves its pending bit unchanged.
- R5: If a line's synchronised level is high in the cycle of an acknowledge, that line's pending bit stays 1. The set wins.
- R6: A write to address 0x00 replaces the whole mask at the write edge. `irq_out` reflects the new mask from the next cycle on.
- R7: The counter of line i increases by exactly 1 for each low-to-high change of the synchronised level. A line held high adds nothing more.
- R8: The counter of line i is read at address 0x40+2i (bits 31:0) and at address 0x41+2i (bits 63:32). Bits above the counter width read as 0.
- R9: Counters wrap to zero on overflow. A build with a 3-bit counter shows 9 rising edges as a count of 1.
- R10: Reset (active-low `rst_n`) clears the mask, the pending bits, the synchroniser and edge state, and every counter. `irq_out` reads 0 after reset.
- R11: Reads have no side effects. Address 0x00 returns the mask, and address 0x01 returns the pending bits. Any other address below 0x40 reads 0. Writes to any address other than 0x00 and 0x01 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Asynchronous level-sensitive request lines |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 7 | Register address for both reads and writes |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
Each fault in the internal state shows up at the ports within one or two cycles.

- **Pending bit:** a bit that is lost or stuck shows in the pending read on the next cycle. It also shows on `irq_out` once the mask enables that line.
- **Acknowledge:** an acknowledge that races a held level would show as the pending bit reading 0 one cycle after the write.
- **Synchroniser:** a wrong stage count moves the first pending read away from the third edge after the input change.
- **Counters:** a miscounted edge shows in the counter halves as soon as that address is read. A wrap fault appears only on the narrow-counter build.

The reference model follows all of this state every cycle. So the first wrong value at either output is reported in the cycle where it appears.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;

  localparam int REG_W     = 32;
  localparam int CNT_EXT_W = 64;
  localparam int ADDR_MASK = 0;
  localparam int ADDR_PEND = 1;

  // Next value of one sticky pending bit: clear on ack, then a live level sets it (set wins).
  function automatic logic sticky_next(input logic cur, input logic clr, input logic lvl);
    return (cur & ~clr) | lvl;
  endfunction

  // Low-to-high change between the previous and the present synchronised level.
  function automatic logic is_rise(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

  // Select one 32-bit half of a zero-extended counter.
  function automatic logic [REG_W-1:0] cnt_half(input logic [CNT_EXT_W-1:0] ext, input logic hi);
    return hi ? ext[CNT_EXT_W-1:REG_W] : ext[REG_W-1:0];
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irq_line_slice.sv
module irq_line_slice
  import irq_sticky_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             lvl_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise_o = is_rise(lvl_i, lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= sticky_next(pend_q, ack_i, lvl_i);
      if (rise_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_sticky_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 64,
  parameter int ADDR_W    = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_W-1:0]                wr_data,
  input  logic [NUM_LINES-1:0]            pend_vec,
  input  logic [NUM_LINES-1:0][CNT_W-1:0] cnt_vec,
  output logic [NUM_LINES-1:0]            mask_q,
  output logic                            mask_wr,
  output logic [NUM_LINES-1:0]            ack_vec,
  output logic [REG_W-1:0]                rd_data
);

  localparam int CNT_BASE = 2 * NUM_LINES;

  logic pend_wr;

  assign mask_wr = wr_en && (addr == ADDR_W'(ADDR_MASK));
  assign pend_wr = wr_en && (addr == ADDR_W'(ADDR_PEND));
  assign ack_vec = pend_wr ? wr_data[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= wr_data[NUM_LINES-1:0];
    end
  end

  always_comb begin
    logic [CNT_EXT_W-1:0] ext;
    rd_data = '0;
    ext     = '0;
    if (addr == ADDR_W'(ADDR_MASK)) begin
      rd_data[NUM_LINES-1:0] = mask_q;
    end else if (addr == ADDR_W'(ADDR_PEND)) begin
      rd_data[NUM_LINES-1:0] = pend_vec;
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      ext = '0;
      ext[CNT_W-1:0] = cnt_vec[i];
      if (addr == ADDR_W'(CNT_BASE + 2*i)) begin
        rd_data = cnt_half(ext, 1'b0);
      end
      if (addr == ADDR_W'(CNT_BASE + 2*i + 1)) begin
        rd_data = cnt_half(ext, 1'b1);
      end
    end
  end

endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_sticky_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(4 * NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wr_data,
  output logic [REG_W-1:0]     reg_rd_data,
  output logic                 irq_out
);

  // Internal events, named so the bound checker can observe them.
  logic [NUM_LINES-1:0]            lvl_vec;
  logic [NUM_LINES-1:0]            ack_vec;
  logic [NUM_LINES-1:0]            pend_vec;
  logic [NUM_LINES-1:0]            rise_vec;
  logic [NUM_LINES-1:0]            mask_q;
  logic                            mask_wr;
  logic [NUM_LINES-1:0][CNT_W-1:0] cnt_vec;

  irq_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_lines),
    .dout (lvl_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_slice #(
      .CNT_W(CNT_W)
    ) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl_vec[g]),
      .ack_i (ack_vec[g]),
      .pend_o(pend_vec[g]),
      .rise_o(rise_vec[g]),
      .cnt_o (cnt_vec[g])
    );
  end

  irq_regfile #(
    .NUM_LINES(NUM_LINES),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wr_data),
    .pend_vec(pend_vec),
    .cnt_vec (cnt_vec),
    .mask_q  (mask_q),
    .mask_wr (mask_wr),
    .ack_vec (ack_vec),
    .rd_data (reg_rd_data)
  );

  assign irq_out = |(pend_vec & mask_q);

endmodule

// File: rtl/irq_sticky_ctrl_chk.sv
module irq_sticky_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int CNT_W     = 64
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            irq_out,
  input logic                            mask_wr,
  input logic [NUM_LINES-1:0]            mask_q,
  input logic [NUM_LINES-1:0]            lvl_vec,
  input logic [NUM_LINES-1:0]            ack_vec,
  input logic [NUM_LINES-1:0]            pend_vec,
  input logic [NUM_LINES-1:0]            rise_vec,
  input logic [NUM_LINES-1:0][CNT_W-1:0] cnt_vec
);

  // R1
  irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out);

  // R1
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_vec != '0));

  // R2
  lvl_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & $past(lvl_vec)) == $past(lvl_vec)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & $past(pend_vec & ~ack_vec)) == $past(pend_vec & ~ack_vec)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & $past(ack_vec & ~lvl_vec)) == '0));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_vec[g] |=> (cnt_vec[g] == $past(cnt_vec[g]) + CNT_W'(1)));
    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_vec[g] |=> $stable(cnt_vec[g]));
  end

endmodule

bind irq_sticky_ctrl irq_sticky_ctrl_chk #(
  .NUM_LINES(NUM_LINES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_out (irq_out),
  .mask_wr (mask_wr),
  .mask_q  (mask_q),
  .lvl_vec (lvl_vec),
  .ack_vec (ack_vec),
  .pend_vec(pend_vec),
  .rise_vec(rise_vec),
  .cnt_vec (cnt_vec)
);

// File: tb/irq_sticky_ctrl_tb.sv
module irq_sticky_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data, wrap_rd;
  logic        irq_out, wrap_irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  irq_sticky_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wr_data(wdata), .reg_rd_data(rd_data), .irq_out(irq_out));

  irq_sticky_ctrl #(.CNT_W(3)) u_wrap (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wr_data(wdata), .reg_rd_data(wrap_rd), .irq_out(wrap_irq));

  // ---------------- behavioural reference model ----------------
  logic [31:0]     m_mask, m_pend, m_prev;
  logic [31:0]     syncq[$];
  longint unsigned m_cnt[32];

  always @(posedge clk) begin
    logic [31:0] lvl, ack;
    if (!rst_n) begin
      m_mask = 0; m_pend = 0; m_prev = 0;
      syncq = '{32'h0, 32'h0};
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      lvl = syncq.pop_front();
      syncq.push_back(lines);
      ack = (wr_en && addr == 7'd1) ? wdata : 32'h0;
      for (int i = 0; i < 32; i++)
        if (lvl[i] && !m_prev[i]) m_cnt[i] = m_cnt[i] + 1;
      m_pend = (m_pend & ~ack) | lvl;
      if (wr_en && addr == 7'd0) m_mask = wdata;
      m_prev = lvl;
    end
  end

  function automatic logic [31:0] model_rd(input logic [6:0] a, input int width);
    longint unsigned c;
    if (a == 7'd0) return m_mask;
    if (a == 7'd1) return m_pend;
    if (a < 7'd64) return 32'h0;
    c = m_cnt[(int'(a) - 64) / 2];
    if (width < 64) c = c & ((64'd1 << width) - 1);
    return a[0] ? c[63:32] : c[31:0];
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // One clock: wait for the falling edge, then compare every output with the model.
  task automatic step();
    @(negedge clk);
    check("irq_out", {31'h0, irq_out}, {31'h0, |(m_pend & m_mask)});
    check("rd_data", rd_data, model_rd(addr, 64));
    check("wrap rd_data", wrap_rd, model_rd(addr, 3));
  endtask

  task automatic cyc(input logic [31:0] ln, input logic we, input logic [6:0] ad,
                     input logic [31:0] wd);
    lines = ln; wr_en = we; addr = ad; wdata = wd;
    step();
  endtask

  task automatic idle(input int n, input logic [31:0] ln, input logic [6:0] ad);
    for (int k = 0; k < n; k++) cyc(ln, 1'b0, ad, 32'h0);
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [31:0] ln;
    // R10 reset state
    cur_req = "R10";
    idle(3, 32'h0, 7'd0);
    rst_n = 1'b1;
    idle(1, 32'h0, 7'd0);
    check("R10 mask after reset", rd_data, 32'h0);
    idle(1, 32'h0, 7'd1);
    check("R10 pend after reset", rd_data, 32'h0);
    idle(1, 32'h0, 7'd64);
    check("R10 counter after reset", rd_data, 32'h0);
    check("R10 irq_out after reset", {31'h0, irq_out}, 32'h0);

    // R2 single-cycle pulse on line 3, latency of two synchroniser flops
    cur_req = "R2";
    cyc(32'h8, 1'b0, 7'd1, 32'h0);
    check("R2 pend after 1 edge", rd_data, 32'h0);
    idle(1, 32'h0, 7'd1);
    check("R2 pend after 2 edges", rd_data, 32'h0);
    idle(1, 32'h0, 7'd1);
    check("R2 pend after 3 edges", rd_data, 32'h8);

    // R3 stays pending after the line dropped
    cur_req = "R3";
    idle(5, 32'h0, 7'd1);
    check("R3 pend held", rd_data, 32'h8);

    // R6 / R1 mask write re-evaluates the output
    cur_req = "R6";
    cyc(32'h0, 1'b1, 7'd0, 32'h0000_0008);
    check("R6 mask readback", rd_data, 32'h8);
    cur_req = "R1";
    check("R1 irq_out with enabled pending", {31'h0, irq_out}, 32'h1);
    cur_req = "R6";
    cyc(32'h0, 1'b1, 7'd0, 32'hFFFF_FFF7);
    check("R6 irq_out after disabling mask", {31'h0, irq_out}, 32'h0);

    // R4 partial acknowledge
    cur_req = "R4";
    cyc(32'h6, 1'b0, 7'd1, 32'h0);
    idle(3, 32'h0, 7'd1);
    check("R4 pend before ack", rd_data, 32'hE);
    cyc(32'h0, 1'b1, 7'd1, 32'h4);
    check("R4 pend after ack of bit2", rd_data, 32'hA);

    // R5 ack races a held level: set wins
    cur_req = "R5";
    idle(4, 32'h80, 7'd1);
    cyc(32'h80, 1'b1, 7'd1, 32'h82);
    check("R5 held line survives ack", rd_data, 32'h88);

    // R7 counting rising edges of line 5 (line 7 still held high)
    cur_req = "R7";
    ln = 32'h80;
    idle(1, ln | 32'h20, 7'd74); idle(2, ln, 7'd74);
    idle(5, ln | 32'h20, 7'd74); idle(2, ln, 7'd74);
    idle(2, ln | 32'h20, 7'd74); idle(3, ln, 7'd74);
    check("R7 line5 edge count", rd_data, 32'd3);
    idle(1, ln, 7'd78);
    check("R7 held line7 counted once", rd_data, 32'd1);

    // R8 high half of a counter
    cur_req = "R8";
    idle(1, ln, 7'd75);
    check("R8 line5 high half", rd_data, 32'd0);

    // R9 wrap on the 3-bit build: 9 edges read as 1
    cur_req = "R9";
    for (int k = 0; k < 9; k++) begin
      idle(1, ln | 32'h1, 7'd64);
      idle(1, ln, 7'd64);
    end
    idle(3, ln, 7'd64);
    check("R9 wide counter", rd_data, 32'd9);
    check("R9 narrow counter wrapped", wrap_rd, 32'd1);

    // R11 writes elsewhere ignored, unmapped reads zero
    cur_req = "R11";
    cyc(ln, 1'b1, 7'd74, 32'hFFFF_FFFF);
    cyc(ln, 1'b1, 7'd2, 32'hFFFF_FFFF);
    idle(1, ln, 7'd74);
    check("R11 counter unchanged by write", rd_data, 32'd3);
    idle(1, ln, 7'd0);
    check("R11 mask unchanged by stray write", rd_data, 32'hFFFF_FFF7);
    idle(1, ln, 7'd3);
    check("R11 unmapped read", rd_data, 32'h0);

    // R1 mixed traffic compared with the model every cycle
    cur_req = "R1";
    lfsr = 32'hACE1_1234;
    ln = 32'h0;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      if (k % 4 == 0) ln = lfsr & {lfsr[15:0], lfsr[31:16]} & lfsr[7] ? 32'h0 : (lfsr & (lfsr >> 3));
      if (lfsr[3:0] == 4'h0) cyc(ln, 1'b1, {6'h0, lfsr[4]}, lfsr ^ {lfsr[7:0], lfsr[31:8]});
      else cyc(ln, 1'b0, (k % 3 == 0) ? {6'h0, k[1]} : 7'(64 + (k % 64)), 32'h0);
    end

    // R10 reset again clears counters and registers
    cur_req = "R10";
    rst_n = 1'b0;
    idle(2, 32'h0, 7'd64);
    rst_n = 1'b1;
    idle(1, 32'h0, 7'd64);
    check("R10 counter cleared", rd_data, 32'h0);
    idle(1, 32'h0, 7'd1);
    check("R10 pend cleared", rd_data, 32'h0);
    idle(1, 32'h0, 7'd0);
    check("R10 mask cleared", rd_data, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule